// File: doc/BRIEF.md
# Byte Device I/O Controller

This block carries out the three byte-wide peripheral operations of a small accumulator machine: probing a peripheral for readiness, pulling one byte from it and pushing one byte to it. The CPU execute stage presents an operation code, an 8-bit peripheral code and the current accumulator, then pulses a start strobe. The controller drives a peripheral select bus, a one-clock read or write strobe and a write byte. It samples the byte returned by the selected peripheral and that peripheral's own ready line.

Every operation runs through the same fixed three-cycle sequence, so the execute stage always knows when the result arrives. A read replaces only the least significant byte of the accumulator. A write sends that byte out and leaves the accumulator as it was. A readiness probe changes no data. It writes a condition code whose "less" value means ready, so that the usual jump-if-less instruction can branch on it.

Top module: `byte_io_ctrl`

## Requirements
- R1: While reset is low and after its release, done_o, dev_rd_o, dev_wr_o and cc_wr_o are 0, acc_o is 0 and cc_o is 2'b01.
- R2: Operation 2'b00 (probe) on a peripheral whose dev_ready_i bit is 1 sets cc_o to 2'b00 (less) and pulses cc_wr_o together with done_o.
- R3: A probe on a peripheral whose ready bit is 0 sets cc_o to 2'b01 (equal). Only probes pulse cc_wr_o, and cc_o never shows 2'b10 after a probe.
- R4: Operation 2'b01 (read) raises dev_rd_o for exactly one cycle with dev_sel_o equal to the code. At done, acc_o[7:0] equals the dev_rdata_i sampled at the clock edge that ends the strobe, and acc_o[23:8] equals the accepted accumulator.
- R5: Operation 2'b10 (write) raises dev_wr_o for exactly one cycle with dev_sel_o equal to the code and dev_wdata_o equal to the accepted accumulator bits 7:0. At done, acc_o equals the accepted accumulator.
- R6: The strobe cycle is the first cycle after the accepting edge. done_o is high for exactly the one cycle that follows it, and dev_sel_o holds its value from the strobe cycle through done.
- R7: Read and write complete on the same schedule whether or not the selected peripheral is ready.
- R8: start_i is accepted only when no operation is in flight. A start raised during the strobe cycle or the done cycle causes no strobe and no extra done.
- R9: Operation 2'b11 raises no strobe and no cc_wr_o. It still yields done_o on the normal schedule, with acc_o equal to the accepted accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe from the execute stage |
| op_i | input | 2 | 00 probe, 01 read, 10 write, 11 no-op |
| code_i | input | 8 | Peripheral code |
| acc_i | input | 24 | Accumulator value |
| acc_o | output | 24 | Updated accumulator, valid while done_o is high |
| cc_o | output | 2 | Condition code: 00 less, 01 equal, 10 greater |
| cc_wr_o | output | 1 | High with done_o when cc_o carries a new probe result |
| done_o | output | 1 | One-cycle completion pulse |
| dev_sel_o | output | 8 | Selected peripheral code |
| dev_rd_o | output | 1 | One-cycle read strobe |
| dev_wr_o | output | 1 | One-cycle write strobe |
| dev_wdata_o | output | 8 | Byte to the peripheral |
| dev_rdata_i | input | 8 | Byte from the selected peripheral |
| dev_ready_i | input | 256 | Ready line of each peripheral, indexed by code |

## Verification
The properties assume that acc_i is stable at the edge where the request is accepted. They compare the accumulator at done with the input two edges earlier, so they rely on the request being taken at that edge and on start_i being a clean level between edges. The stimulus drives all inputs only at falling edges. It returns start_i low after each accepted request, except in the deliberate overlap test. It also sweeps every peripheral code with several ready patterns, so both probe outcomes appear for every code.

// File: rtl/byte_io_pkg.sv
package byte_io_pkg;
   typedef enum logic [1:0] {
      OP_PROBE = 2'b00,
      OP_READ  = 2'b01,
      OP_WRITE = 2'b10,
      OP_NONE  = 2'b11
   } io_op_e;

   typedef enum logic [1:0] {
      CC_LT = 2'b00,
      CC_EQ = 2'b01,
      CC_GT = 2'b10
   } cc_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_ACT  = 2'b01,
      ST_DONE = 2'b10
   } io_st_e;
endpackage

// File: rtl/io_ready_sel.sv
module io_ready_sel #(
   parameter int CODE_W     = 8,
   parameter bit ONEHOT_SEL = 1'b0,
   localparam int NDEV      = 1 << CODE_W
) (
   input  logic [NDEV-1:0]   ready_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              ready_o
);
   initial begin
      assert (CODE_W >= 1 && CODE_W <= 10) else $error("io_ready_sel: CODE_W out of range");
   end

   generate
      if (ONEHOT_SEL) begin : g_onehot
         logic [NDEV-1:0] hit;
         for (genvar i = 0; i < NDEV; i++) begin : g_dec
            assign hit[i] = (code_i == CODE_W'(i)) && ready_i[i];
         end
         assign ready_o = |hit;
      end else begin : g_index
         assign ready_o = ready_i[code_i];
      end
   endgenerate
endmodule

// File: rtl/io_acc_merge.sv
module io_acc_merge #(
   parameter int ACC_W  = 24,
   parameter int DATA_W = 8
) (
   input  logic [ACC_W-1:0]  acc_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              load_i,
   output logic [ACC_W-1:0]  acc_o
);
   initial begin
      assert (DATA_W >= 1 && DATA_W <= ACC_W) else $error("io_acc_merge: DATA_W must fit in ACC_W");
   end

   generate
      if (DATA_W == ACC_W) begin : g_full
         assign acc_o = load_i ? byte_i : acc_i;
      end else begin : g_part
         assign acc_o = {acc_i[ACC_W-1:DATA_W], (load_i ? byte_i : acc_i[DATA_W-1:0])};
      end
   endgenerate
endmodule

// File: rtl/io_seq.sv
module io_seq
   import byte_io_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   input  io_op_e op_i,
   output logic   accept_o,
   output logic   act_o,
   output io_op_e op_o,
   output logic   rd_stb_o,
   output logic   wr_stb_o,
   output logic   done_o
);
   io_st_e st_q;
   io_op_e op_q;

   assign accept_o = (st_q == ST_IDLE) && start_i;
   assign act_o    = (st_q == ST_ACT);
   assign op_o     = op_q;
   assign rd_stb_o = act_o && (op_q == OP_READ);
   assign wr_stb_o = act_o && (op_q == OP_WRITE);
   assign done_o   = (st_q == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         op_q <= OP_NONE;
      end else begin
         case (st_q)
            ST_IDLE: if (start_i) begin
               st_q <= ST_ACT;
               op_q <= op_i;
            end
            ST_ACT:  st_q <= ST_DONE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R6: a strobe is followed by done in the next cycle
   p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_o || wr_stb_o) |=> done_o);
   // R6: done lasts one cycle
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R4 / R5: strobes last one cycle and never overlap
   p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_o || wr_stb_o) |=> !(rd_stb_o || wr_stb_o));
   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb_o && wr_stb_o));
   // R8: a start seen while busy launches nothing in the next cycle
   p_busy_ignores_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_o || done_o) |=> !(rd_stb_o || wr_stb_o));
endmodule

// File: rtl/byte_io_ctrl.sv
module byte_io_ctrl
   import byte_io_pkg::*;
#(
   parameter int ACC_W      = 24,
   parameter int DATA_W     = 8,
   parameter int CODE_W     = 8,
   parameter bit ONEHOT_SEL = 1'b0,
   localparam int NDEV      = 1 << CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [ACC_W-1:0]  acc_i,
   output logic [ACC_W-1:0]  acc_o,
   output logic [1:0]        cc_o,
   output logic              cc_wr_o,
   output logic              done_o,
   output logic [CODE_W-1:0] dev_sel_o,
   output logic              dev_rd_o,
   output logic              dev_wr_o,
   output logic [DATA_W-1:0] dev_wdata_o,
   input  logic [DATA_W-1:0] dev_rdata_i,
   input  logic [NDEV-1:0]   dev_ready_i
);
   initial begin
      assert (ACC_W > DATA_W) else $error("byte_io_ctrl: ACC_W must exceed DATA_W");
      assert (CODE_W >= 1 && CODE_W <= 10) else $error("byte_io_ctrl: CODE_W out of range");
   end

   logic              accept, act, seq_done;
   io_op_e            op_q;
   logic [CODE_W-1:0] code_q;
   logic [ACC_W-1:0]  acc_q, acc_merged;
   cc_e               cc_q;
   logic              sel_ready;

   io_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .op_i     (io_op_e'(op_i)),
      .accept_o (accept),
      .act_o    (act),
      .op_o     (op_q),
      .rd_stb_o (dev_rd_o),
      .wr_stb_o (dev_wr_o),
      .done_o   (seq_done)
   );

   io_ready_sel #(.CODE_W(CODE_W), .ONEHOT_SEL(ONEHOT_SEL)) u_rdy (
      .ready_i (dev_ready_i),
      .code_i  (code_q),
      .ready_o (sel_ready)
   );

   io_acc_merge #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_merge (
      .acc_i  (acc_q),
      .byte_i (dev_rdata_i),
      .load_i (dev_rd_o),
      .acc_o  (acc_merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         acc_q  <= '0;
         cc_q   <= CC_EQ;
      end else if (accept) begin
         code_q <= code_i;
         acc_q  <= acc_i;
      end else if (act) begin
         acc_q <= acc_merged;
         if (op_q == OP_PROBE) cc_q <= sel_ready ? CC_LT : CC_EQ;
      end
   end

   assign acc_o       = acc_q;
   assign cc_o        = cc_q;
   assign done_o      = seq_done;
   assign cc_wr_o     = seq_done && (op_q == OP_PROBE);
   assign dev_sel_o   = code_q;
   assign dev_wdata_o = acc_q[DATA_W-1:0];

   // R1: quiet outputs right after reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !(done_o || dev_rd_o || dev_wr_o || cc_wr_o));
   // R3: a probe result is never "greater"
   p_probe_cc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cc_wr_o |-> (cc_o != 2'(CC_GT)));
   // R4: read keeps the upper accumulator bits from acceptance
   p_read_keeps_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && op_q == OP_READ) |-> acc_o[ACC_W-1:DATA_W] == $past(acc_i[ACC_W-1:DATA_W], 2));
   // R5: write byte is the accepted accumulator low byte
   p_write_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_wr_o |-> dev_wdata_o == $past(acc_i[DATA_W-1:0]));
   // R6: peripheral select holds from strobe to done
   p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $stable(dev_sel_o));
   // R9: the no-op raises no strobe in the cycle after acceptance
   p_none_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_i == 2'(OP_NONE)) |=> !(dev_rd_o || dev_wr_o));
endmodule

// File: tb/byte_io_ctrl_tb_top.sv
module byte_io_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NDEV = 256;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [1:0]  op_i;
   logic [7:0]  code_i;
   logic [23:0] acc_i;
   logic [23:0] acc_o;
   logic [1:0]  cc_o;
   logic        cc_wr_o, done_o, dev_rd_o, dev_wr_o;
   logic [7:0]  dev_sel_o, dev_wdata_o, dev_rdata_i;
   logic [NDEV-1:0] rdy;

   int checks = 0;
   int fails  = 0;
   int rd_cnt [NDEV];
   int wr_cnt [NDEV];
   logic [7:0] wr_last [NDEV];

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_io_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .code_i(code_i),
      .acc_i(acc_i), .acc_o(acc_o), .cc_o(cc_o), .cc_wr_o(cc_wr_o), .done_o(done_o),
      .dev_sel_o(dev_sel_o), .dev_rd_o(dev_rd_o), .dev_wr_o(dev_wr_o),
      .dev_wdata_o(dev_wdata_o), .dev_rdata_i(dev_rdata_i), .dev_ready_i(rdy)
   );

   function automatic logic [7:0] dev_byte(input int c, input int n);
      return 8'((c * 13 + n * 29 + 7) & 255);
   endfunction

   assign dev_rdata_i = dev_byte(int'(dev_sel_o), rd_cnt[dev_sel_o]);

   always @(posedge clk) begin
      if (dev_rd_o) rd_cnt[dev_sel_o] <= rd_cnt[dev_sel_o] + 1;
      if (dev_wr_o) begin
         wr_cnt[dev_sel_o]  <= wr_cnt[dev_sel_o] + 1;
         wr_last[dev_sel_o] <= dev_wdata_o;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_ready(input int k);
      for (int i = 0; i < NDEV; i++) rdy[i] = (((i * 5) + k) % 3) == 0;
   endtask

   // one full operation, checked at each stage
   task automatic run_op(input logic [1:0] op, input logic [7:0] code, input logic [23:0] acc);
      logic [7:0]  exp_byte;
      logic [23:0] exp_acc;
      int          wc;
      exp_byte = dev_byte(int'(code), rd_cnt[code]);
      wc = wr_cnt[code];
      @(negedge clk);
      start_i = 1'b1; op_i = op; code_i = code; acc_i = acc;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0; acc_i = ~acc;
      chk(dev_rd_o == (op == 2'b01), "R4", dev_rd_o, op == 2'b01);
      chk(dev_wr_o == (op == 2'b10), "R5", dev_wr_o, op == 2'b10);
      chk(done_o == 1'b0, "R6", done_o, 0);
      if (op != 2'b11) chk(dev_sel_o == code, "R6", dev_sel_o, code);
      if (op == 2'b10) chk(dev_wdata_o == acc[7:0], "R5", dev_wdata_o, acc[7:0]);
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b1, "R6", done_o, 1);
      chk(!dev_rd_o && !dev_wr_o, "R6", {dev_rd_o, dev_wr_o}, 0);
      chk(cc_wr_o == (op == 2'b00), "R3", cc_wr_o, op == 2'b00);
      exp_acc = (op == 2'b01) ? {acc[23:8], exp_byte} : acc;
      case (op)
         2'b00: begin
            chk(cc_o == (rdy[code] ? 2'b00 : 2'b01), rdy[code] ? "R2" : "R3",
                cc_o, rdy[code] ? 0 : 1);
            chk(acc_o == exp_acc, "R2", acc_o, exp_acc);
         end
         2'b01: chk(acc_o == exp_acc, rdy[code] ? "R4" : "R7", acc_o, exp_acc);
         2'b10: begin
            chk(acc_o == exp_acc, "R5", acc_o, exp_acc);
            chk(wr_cnt[code] == wc + 1 && wr_last[code] == acc[7:0], "R5",
                wr_last[code], acc[7:0]);
         end
         default: chk(acc_o == exp_acc, "R9", acc_o, exp_acc);
      endcase
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0, "R6", done_o, 0);
   endtask

   bit finished = 0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NDEV; i++) begin
         rd_cnt[i] = 0; wr_cnt[i] = 0; wr_last[i] = 8'h00;
      end
      rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; code_i = 8'h00; acc_i = 24'h0;
      set_ready(0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!done_o && !dev_rd_o && !dev_wr_o && !cc_wr_o, "R1", done_o, 0);
      chk(acc_o == 24'h0 && cc_o == 2'b01, "R1", {acc_o, cc_o}, 2'b01);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_o && !dev_rd_o && !dev_wr_o && !cc_wr_o, "R1", done_o, 0);

      // probe sweep over every code with three ready patterns (R2, R3)
      for (int k = 0; k < 3; k++) begin
         set_ready(k);
         for (int c = 0; c < NDEV; c++)
            run_op(2'b00, 8'(c), 24'((c * 4099 + k * 77) & 24'hFFFFFF));
      end

      // reads and writes over every code, ready or not (R4, R5, R7)
      set_ready(1);
      for (int c = 0; c < NDEV; c++) begin
         run_op(2'b01, 8'(c), 24'((c * 70001 + 24'h5A5A00) & 24'hFFFFFF));
         run_op(2'b10, 8'(c), 24'((c * 1237 + 24'hA00011) & 24'hFFFFFF));
      end
      // boundary accumulators
      run_op(2'b01, 8'hFF, 24'hFFFFFF);
      run_op(2'b01, 8'h00, 24'h000000);
      run_op(2'b10, 8'hFF, 24'hFFFFFF);
      run_op(2'b10, 8'h00, 24'hFFFF00);

      // no-op (R9)
      for (int c = 0; c < 8; c++) run_op(2'b11, 8'(c * 31), 24'h123456 + 24'(c));

      // start held through the busy cycles (R8)
      begin
         int wc9, rc5;
         logic [7:0] eb;
         wc9 = wr_cnt[9]; rc5 = rd_cnt[5];
         eb = dev_byte(5, rd_cnt[5]);
         @(negedge clk);
         start_i = 1'b1; op_i = 2'b01; code_i = 8'd5; acc_i = 24'hABCD00;
         @(posedge clk);
         @(negedge clk);
         op_i = 2'b10; code_i = 8'd9; acc_i = 24'h000077;
         chk(dev_rd_o && !dev_wr_o, "R8", {dev_rd_o, dev_wr_o}, 2'b10);
         @(posedge clk);
         @(negedge clk);
         chk(done_o && !dev_wr_o && !dev_rd_o, "R8", {done_o, dev_wr_o}, 2'b10);
         chk(acc_o == {16'hABCD, eb}, "R8", acc_o, {16'hABCD, eb});
         start_i = 1'b0;
         @(posedge clk);
         @(negedge clk);
         chk(!done_o && !dev_wr_o && !dev_rd_o, "R8", done_o, 0);
         @(posedge clk);
         @(negedge clk);
         chk(!done_o && wr_cnt[9] == wc9 && rd_cnt[5] == rc5 + 1, "R8", wr_cnt[9], wc9);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule